// File: doc/BRIEF.md
# Synchronous Serial Port Transceiver

This block moves parallel words over a four-wire synchronous serial link made of a bit clock, a frame sync, a transmit data line and a receive data line. Transmitter and receiver always share the same bit clock and frame sync, and both follow one bit-position counter. A word written on the parallel side is shifted out on the transmit line. Received bits are gathered into a word that is presented with a one-cycle strobe.

Two clocking styles are available. With a continuous clock, the bit clock never pauses. Each frame is `SLOT_BITS` bit periods long, the data word fills its first `WORD_W` positions, and a frame sync pulse marks the word. The pulse can last one bit or the whole word, and can be moved one bit period earlier. With a gated clock, there is no frame sync. The clock runs only while a word is being moved, and every `WORD_W` clock periods form one word.

The bit clock and the frame sync each have their own direction control. An internal bit clock is divided down from the system clock. External bit clock, frame sync and receive data are synchronised into the system clock domain and edge-detected there.

Top module: `sspt_top`

## Requirements
- R1: Transmitter and receiver share one bit clock and one bit-position counter. When the transmit line is looped back to the receive line, each received word equals the transmitted word.
- R2: With an internal bit clock (`cfg_bclk_int`=1), each half period of `bclk_out` lasts `cfg_div`+1 system clock cycles. `bclk_out` is low after reset.
- R3: In continuous mode a frame is `SLOT_BITS` bit periods long. Positions 0 to `WORD_W`-1 carry the data word, and `txd` is 0 in every later position.
- R4: With bit-length sync (`cfg_fs_word`=0, `cfg_fs_early`=0), `fs_out` is high only during position 0.
- R5: With word-length sync (`cfg_fs_word`=1, `cfg_fs_early`=0), `fs_out` is high during positions 0 to `WORD_W`-1.
- R6: Early sync (`cfg_fs_early`=1) moves the pulse one bit period earlier. For bit-length sync the pulse falls on position `SLOT_BITS`-1 only. For word-length sync it covers position `SLOT_BITS`-1 and positions 0 to `WORD_W`-2.
- R7: With `cfg_lsb_first`=0, position p carries word bit `WORD_W`-1-p. With `cfg_lsb_first`=1, it carries word bit p. The same order applies on transmit and on receive.
- R8: `txd` and `fs_out` change only on a rising bit-clock edge. Receive data is taken on the falling edge.
- R9: After the bit at position `WORD_W`-1 is received, `rx_valid` is high for exactly one cycle with the assembled word on `rx_data`.
- R10: At each word start the transmitter loads the most recently written word. A write in the same cycle as the word start is loaded at once. If no word was written since the last load, the previous word is sent again and `tx_underrun` pulses for one cycle.
- R11: In gated mode `fs_out` stays 0. With an internal clock, `bclk_out` idles low and produces exactly `WORD_W` rising edges per written word. A word begins on the first rising edge after the clock resumes.
- R12: With an external frame sync, a low-to-high change of the sync sampled on a falling edge realigns the position. Without early sync the current bit becomes position 0. With early sync the next bit becomes position 0.
- R13: `bclk_oe` equals `cfg_bclk_int` and `fs_oe` equals `cfg_fs_int`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gated | input | 1 | 1 selects gated clock, 0 selects continuous clock |
| cfg_bclk_int | input | 1 | 1 drives the bit clock from the block |
| cfg_fs_int | input | 1 | 1 drives the frame sync from the block |
| cfg_fs_word | input | 1 | 1 selects word-length sync, 0 selects bit-length sync |
| cfg_fs_early | input | 1 | 1 places the sync one bit period early |
| cfg_lsb_first | input | 1 | 1 shifts the least significant bit first |
| cfg_div | input | DIV_W | Internal half period minus one, in system cycles |
| tx_data | input | WORD_W | Word to transmit |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_underrun | output | 1 | One-cycle pulse when a word start finds no new word |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_data |
| bclk_in | input | 1 | External bit clock |
| bclk_out | output | 1 | Internal bit clock |
| bclk_oe | output | 1 | Output enable for bclk_out |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Internal frame sync |
| fs_oe | output | 1 | Output enable for fs_out |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |

## Verification
The assertions rely on a few assumptions about the inputs. Configuration changes only while reset is held. `cfg_div` is at least 2. An external bit clock has half periods several system cycles long. The external link holds `rxd` and `fs_in` constant between rising edges. The bench changes configuration only under reset and drives every external clock phase for six system cycles. It updates external sync and data only together with a rising edge. When it drives a non-early external sync, it starts the first frame on the first clock edge after reset, so that the position counter and the sync agree from the first word.

// File: rtl/sspt_pkg.sv
package sspt_pkg;

    typedef struct packed {
        logic rise;
        logic fall;
    } bclk_edge_t;

    typedef struct packed {
        logic gated;
        logic fs_int;
        logic word;
        logic early;
    } fs_cfg_t;

    // Sync level expected at bit position p of a frame of slot positions
    function automatic logic fs_level(int unsigned p, int unsigned w,
                                      int unsigned slot, logic word, logic early);
        if (early) begin
            if (word) return (p == slot - 1) || (p + 1 < w);
            return p == slot - 1;
        end
        if (word) return p < w;
        return p == 0;
    endfunction

    // Word bit carried at bit position p
    function automatic int unsigned bit_index(int unsigned p, int unsigned w, logic lsb);
        if (lsb) return p;
        return w - 1 - p;
    endfunction

endpackage

// File: rtl/sspt_sync.sv
module sspt_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sspt_clkgen.sv
module sspt_clkgen
    import sspt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_int,
    input  logic [DIV_W-1:0] div,
    input  logic             run_ok,
    input  logic             bclk_s,
    output logic             bclk_q,
    output bclk_edge_t       edg
);
    logic [DIV_W-1:0] cnt;
    logic             ext_d;
    logic             tick;

    assign tick = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            bclk_q <= 1'b0;
            ext_d  <= 1'b0;
        end else begin
            ext_d <= bclk_s;
            if (bclk_int) begin
                if (tick) begin
                    cnt <= '0;
                    if (bclk_q || run_ok) bclk_q <= ~bclk_q;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt    <= '0;
                bclk_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (bclk_int) begin
            edg.rise = tick && !bclk_q && run_ok;
            edg.fall = tick && bclk_q;
        end else begin
            edg.rise = bclk_s && !ext_d;
            edg.fall = !bclk_s && ext_d;
        end
    end

    // R2
    half_period_chk: assert property (@(posedge clk) disable iff (rst)
        (bclk_int && $past(bclk_int) && !$stable(bclk_q)) |-> ($past(cnt) == $past(div)));

    // R8
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(edg.rise && edg.fall));
endmodule

// File: rtl/sspt_framer.sv
module sspt_framer
    import sspt_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int SLOT_BITS = 16,
    localparam int PW = $clog2(SLOT_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  fs_cfg_t       fcfg,
    input  bclk_edge_t    edg,
    input  logic          fs_s,
    output logic [PW-1:0] pos,
    output logic [PW-1:0] rx_pos,
    output logic          rx_take,
    output logic          frame_start,
    output logic          idle,
    output logic          fs_q
);
    localparam logic [PW-1:0] LAST_G = PW'(WORD_W - 1);
    localparam logic [PW-1:0] LAST_C = PW'(SLOT_BITS - 1);

    logic [PW-1:0] last;
    logic [PW-1:0] pos_nxt;
    logic          fs_prev;
    logic          resync;

    assign last        = fcfg.gated ? LAST_G : LAST_C;
    assign pos_nxt     = (pos == last) ? '0 : pos + 1'b1;
    assign idle        = (pos == last);
    assign frame_start = edg.rise && (pos_nxt == '0);
    assign resync      = edg.fall && !fcfg.gated && !fcfg.fs_int && fs_s && !fs_prev;
    assign rx_pos      = resync ? (fcfg.early ? last : '0) : pos;
    assign rx_take     = edg.fall && (rx_pos < PW'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= last;
            fs_q    <= 1'b0;
            fs_prev <= 1'b0;
        end else begin
            if (edg.rise) begin
                pos  <= pos_nxt;
                fs_q <= !fcfg.gated &&
                        fs_level(32'(pos_nxt), WORD_W, SLOT_BITS, fcfg.word, fcfg.early);
            end
            if (edg.fall) begin
                fs_prev <= fs_s;
                if (resync) pos <= rx_pos;
            end
        end
    end

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos <= last);

    // R3
    frame_origin_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (pos == '0));

    // R8
    fs_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fs_q) |-> $past(edg.rise));
endmodule

// File: rtl/sspt_tx.sv
module sspt_tx
    import sspt_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int PW     = 4,
    localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lsb,
    input  logic              frame_start,
    input  logic [PW-1:0]     pos,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_wr,
    output logic              txd,
    output logic              tx_underrun,
    output logic              pending
);
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] buf_q;
    logic              full_q;
    logic [IW-1:0]     idx;

    assign pending = full_q || tx_wr;
    assign idx     = IW'(bit_index(32'(pos), WORD_W, lsb));
    assign txd     = (pos < PW'(WORD_W)) ? cur[idx] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= '0;
            buf_q       <= '0;
            full_q      <= 1'b0;
            tx_underrun <= 1'b0;
        end else begin
            tx_underrun <= 1'b0;
            if (frame_start) begin
                if (tx_wr) begin
                    cur    <= tx_data;
                    full_q <= 1'b0;
                end else if (full_q) begin
                    cur    <= buf_q;
                    full_q <= 1'b0;
                end else begin
                    tx_underrun <= 1'b1;
                end
            end else if (tx_wr) begin
                buf_q  <= tx_data;
                full_q <= 1'b1;
            end
        end
    end

    // R10
    underrun_start_chk: assert property (@(posedge clk) disable iff (rst)
        tx_underrun |-> ($past(frame_start) && !$past(full_q) && !$past(tx_wr)));

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_start) |-> $stable(cur));
endmodule

// File: rtl/sspt_rx.sv
module sspt_rx
    import sspt_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int PW     = 4,
    localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lsb,
    input  logic              take,
    input  logic [PW-1:0]     pos,
    input  logic              din,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] word_c;
    logic [IW-1:0]     idx;

    assign idx = IW'(bit_index(32'(pos), WORD_W, lsb));

    always_comb begin
        word_c      = acc;
        word_c[idx] = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (take) begin
                acc <= word_c;
                if (pos == PW'(WORD_W - 1)) begin
                    rx_data  <= word_c;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // R9
    rx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_data));
endmodule

// File: rtl/sspt_top.sv
module sspt_top
    import sspt_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int SLOT_BITS = 16,
    parameter int DIV_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_gated,
    input  logic              cfg_bclk_int,
    input  logic              cfg_fs_int,
    input  logic              cfg_fs_word,
    input  logic              cfg_fs_early,
    input  logic              cfg_lsb_first,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_wr,
    output logic              tx_underrun,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              bclk_in,
    output logic              bclk_out,
    output logic              bclk_oe,
    input  logic              fs_in,
    output logic              fs_out,
    output logic              fs_oe,
    input  logic              rxd,
    output logic              txd
);
    localparam int PW = $clog2(SLOT_BITS);

    fs_cfg_t       fcfg;
    bclk_edge_t    edg;
    logic [2:0]    raw;
    logic [2:0]    syn;
    logic          run_ok;
    logic          idle;
    logic          pending;
    logic          frame_start;
    logic          rx_take;
    logic [PW-1:0] pos;
    logic [PW-1:0] rx_pos;

    assign fcfg = '{gated: cfg_gated, fs_int: cfg_fs_int,
                    word: cfg_fs_word, early: cfg_fs_early};
    assign raw  = {bclk_in, fs_in, rxd};

    assign run_ok  = !cfg_gated || !idle || pending;
    assign bclk_oe = cfg_bclk_int;
    assign fs_oe   = cfg_fs_int;

    sspt_sync #(.N(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    sspt_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .bclk_int (cfg_bclk_int),
        .div      (cfg_div),
        .run_ok   (run_ok),
        .bclk_s   (syn[2]),
        .bclk_q   (bclk_out),
        .edg      (edg)
    );

    sspt_framer #(.WORD_W(WORD_W), .SLOT_BITS(SLOT_BITS)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .fcfg        (fcfg),
        .edg         (edg),
        .fs_s        (syn[1]),
        .pos         (pos),
        .rx_pos      (rx_pos),
        .rx_take     (rx_take),
        .frame_start (frame_start),
        .idle        (idle),
        .fs_q        (fs_out)
    );

    sspt_tx #(.WORD_W(WORD_W), .PW(PW)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .lsb         (cfg_lsb_first),
        .frame_start (frame_start),
        .pos         (pos),
        .tx_data     (tx_data),
        .tx_wr       (tx_wr),
        .txd         (txd),
        .tx_underrun (tx_underrun),
        .pending     (pending)
    );

    sspt_rx #(.WORD_W(WORD_W), .PW(PW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .lsb      (cfg_lsb_first),
        .take     (rx_take),
        .pos      (rx_pos),
        .din      (syn[0]),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    // R11
    gated_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_gated && cfg_bclk_int && !bclk_out && idle && !pending) |=> !bclk_out);

    // R11
    gated_nosync_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_gated |-> !fs_out);
endmodule

// File: tb/tb_sspt_top.sv
module tb_sspt_top;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int SLOT = 16;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_gated = 0, cfg_bclk_int = 1, cfg_fs_int = 1;
    logic       cfg_fs_word = 0, cfg_fs_early = 0, cfg_lsb_first = 0;
    logic [7:0] cfg_div = 8'd2;
    logic [W-1:0] tx_data = '0;
    logic       tx_wr = 0;
    logic       tx_underrun;
    logic [W-1:0] rx_data;
    logic       rx_valid;
    logic       bclk_in = 0, fs_in = 0, rxd_drv = 0, loop = 0;
    logic       bclk_out, bclk_oe, fs_out, fs_oe, txd;
    logic       rxd_w;

    assign rxd_w = loop ? txd : rxd_drv;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int rx_cnt, ucnt, nrise, fs_hi;
    logic [W-1:0] rx_log [8];
    logic bclk_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    sspt_top dut (
        .clk(clk), .rst(rst),
        .cfg_gated(cfg_gated), .cfg_bclk_int(cfg_bclk_int), .cfg_fs_int(cfg_fs_int),
        .cfg_fs_word(cfg_fs_word), .cfg_fs_early(cfg_fs_early), .cfg_lsb_first(cfg_lsb_first),
        .cfg_div(cfg_div), .tx_data(tx_data), .tx_wr(tx_wr), .tx_underrun(tx_underrun),
        .rx_data(rx_data), .rx_valid(rx_valid), .bclk_in(bclk_in), .bclk_out(bclk_out),
        .bclk_oe(bclk_oe), .fs_in(fs_in), .fs_out(fs_out), .fs_oe(fs_oe),
        .rxd(rxd_w), .txd(txd)
    );

    always @(negedge clk) begin
        if (rst) begin
            rx_cnt = 0; ucnt = 0; nrise = 0; fs_hi = 0; bclk_prev = 0;
        end else begin
            if (rx_valid) begin
                if (rx_cnt < 8) rx_log[rx_cnt] = rx_data;
                rx_cnt++;
            end
            if (tx_underrun) ucnt++;
            if (bclk_out && !bclk_prev) nrise++;
            if (fs_out) fs_hi++;
            bclk_prev = bclk_out;
        end
    end

    function automatic bit m_fs(int p, bit word, bit early);
        if (!early) return word ? (p < W) : (p == 0);
        return word ? (p == SLOT-1 || p < W-1) : (p == SLOT-1);
    endfunction

    function automatic bit m_bit(logic [W-1:0] w, int p, bit lsb);
        if (p >= W) return 1'b0;
        return lsb ? w[p] : w[W-1-p];
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(bit g, bit bi, bit fi, bit wd, bit er, bit lb, int dv, bit lp);
        @(negedge clk);
        rst = 1; tx_wr = 0; bclk_in = 0; fs_in = 0; rxd_drv = 0;
        cfg_gated = g; cfg_bclk_int = bi; cfg_fs_int = fi;
        cfg_fs_word = wd; cfg_fs_early = er; cfg_lsb_first = lb;
        cfg_div = 8'(dv); loop = lp;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic write_word(logic [W-1:0] w);
        tx_data = w; tx_wr = 1;
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic drive_bit(bit fsv, bit dv, output bit tx_s);
        bclk_in = 1; fs_in = fsv; rxd_drv = dv;
        repeat (HALF-1) @(negedge clk);
        tx_s = txd;
        @(negedge clk);
        bclk_in = 0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst = 1; loop = 0;
        cfg_gated = 0; cfg_bclk_int = 1; cfg_fs_int = 1;
        repeat (3) @(negedge clk);
        chk("R2 reset bclk_out", bclk_out, 0);
        chk("R8 reset fs_out", fs_out, 0);
        chk("R9 reset rx_valid", rx_valid, 0);
        chk("R10 reset tx_underrun", tx_underrun, 0);
        chk("R3 reset txd", txd, 0);
    endtask

    task automatic t_master_cont(bit wd, bit er, bit lb, int dv);
        logic [W-1:0] a = 8'hB4, b = 8'h1D;
        time t0 = 0;
        do_reset(0, 1, 1, wd, er, lb, dv, 1);
        write_word(a);
        chk("R13 bclk_oe master", bclk_oe, 1);
        chk("R13 fs_oe master", fs_oe, 1);
        for (int k = 0; k < 3*SLOT; k++) begin
            int p = k % SLOT;
            int f = k / SLOT;
            @(posedge bclk_out);
            @(negedge clk);
            if (k == 0) t0 = $time;
            if (k == 1) chk("R2 bit period", int'($time - t0), 2*(dv+1)*CLK_PERIOD);
            chk($sformatf("R4/R5/R6 fs frame %0d pos %0d", f, p), fs_out, m_fs(p, wd, er));
            chk($sformatf("R3/R7/R8 txd frame %0d pos %0d", f, p), txd,
                m_bit((f == 2) ? b : a, p, lb));
            if (k == SLOT + 3) write_word(b);
        end
        repeat (4) @(negedge clk);
        chk("R9 rx count", rx_cnt, 3);
        chk("R1 rx word 0", rx_log[0], a);
        chk("R1 rx word 1", rx_log[1], a);
        chk("R1 rx word 2", rx_log[2], b);
        chk("R10 underrun count", ucnt, 1);
    endtask

    task automatic wait_rx(int n);
        for (int i = 0; i < 2000 && rx_cnt < n; i++) @(negedge clk);
    endtask

    task automatic t_gated_master(bit lb);
        logic [W-1:0] c = 8'h3C, d = 8'hE1;
        do_reset(1, 1, 1, 0, 0, lb, 2, 1);
        repeat (20) @(negedge clk);
        chk("R11 no clock while idle", nrise, 0);
        write_word(c);
        wait_rx(1);
        repeat (40) @(negedge clk);
        chk("R11 rises per word", nrise, W);
        chk("R11 clock parked low", bclk_out, 0);
        chk("R1 gated rx word 0", rx_log[0], c);
        write_word(d);
        wait_rx(2);
        repeat (40) @(negedge clk);
        chk("R11 rises two words", nrise, 2*W);
        chk("R1 gated rx word 1", rx_log[1], d);
        chk("R11 gated fs stays low", fs_hi, 0);
        chk("R10 gated master no underrun", ucnt, 0);
    endtask

    task automatic t_slave_cont(bit wd, bit er, bit lb);
        logic [W-1:0] e = 8'h96, f2 = 8'h4B, r0 = 8'hC5, r1 = 8'h2E;
        bit s;
        do_reset(0, 0, 0, wd, er, lb, 2, 0);
        chk("R13 bclk_oe slave", bclk_oe, 0);
        chk("R13 fs_oe slave", fs_oe, 0);
        write_word(e);
        if (er) begin
            repeat (3) drive_bit(0, 0, s);
            drive_bit(1, 0, s);
        end
        for (int g = 0; g < 2*SLOT; g++) begin
            int p  = g % SLOT;
            int fr = g / SLOT;
            drive_bit(m_fs(p, wd, er), m_bit(fr ? r1 : r0, p, lb), s);
            chk($sformatf("R12 slave txd frame %0d pos %0d", fr, p), s,
                m_bit(fr ? f2 : e, p, lb));
            if (fr == 0 && p == 3) write_word(f2);
        end
        repeat (10) @(negedge clk);
        chk("R9 slave rx count", rx_cnt, 2);
        chk("R12 slave rx word 0", rx_log[0], r0);
        chk("R12 slave rx word 1", rx_log[1], r1);
        chk("R10 slave underrun count", ucnt, er ? 1 : 0);
    endtask

    task automatic t_gated_slave();
        logic [W-1:0] g = 8'h71, h = 8'hA9, j = 8'h5E;
        bit s;
        do_reset(1, 0, 1, 0, 0, 0, 2, 0);
        write_word(g);
        for (int p = 0; p < W; p++) begin
            drive_bit(0, m_bit(h, p, 0), s);
            chk($sformatf("R11 gated slave txd word 0 pos %0d", p), s, m_bit(g, p, 0));
        end
        repeat (30) @(negedge clk);
        chk("R9 gated slave rx count", rx_cnt, 1);
        chk("R11 gated slave rx word 0", rx_log[0], h);
        chk("R10 gated slave no underrun", ucnt, 0);
        for (int p = 0; p < W; p++) begin
            drive_bit(0, m_bit(j, p, 0), s);
            chk($sformatf("R10 resent word pos %0d", p), s, m_bit(g, p, 0));
        end
        repeat (10) @(negedge clk);
        chk("R11 gated slave rx word 1", rx_log[1], j);
        chk("R10 gated slave underrun", ucnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_master_cont(0, 0, 0, 2);
        t_master_cont(1, 0, 1, 3);
        t_master_cont(0, 1, 0, 2);
        t_master_cont(1, 1, 1, 2);
        t_gated_master(0);
        t_gated_master(1);
        t_slave_cont(0, 0, 0);
        t_slave_cont(1, 1, 1);
        t_gated_slave();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule